// File: doc/BRIEF.md
# Segmented-Carry Message Schedule Generator

This block expands one 512-bit message block into the 64 schedule words consumed by a SHA-256 style compression core, delivering one 32-bit word per round. A load strobe captures the block. Rounds 0 to 15 present the block's own words, most significant word first. Each later round derives its word from four earlier words through two mixing functions, each built from rotations, a shift and XOR, and three additions.

Every addition in the recurrence is a segmented adder. The 32-bit operands are cut into independent slices of `SEG_W` bits, and each slice is summed modulo 2^SEG_W. No carry passes from one slice into the next. This shortens the carry chain at the cost of exactness. The schedule matches standard SHA-256 only when `SEG_W` is 32; narrower settings give a deliberately different word stream. The consumer steps through rounds with an advance input. A done flag marks the point where the last word has been consumed.

Top module: `seg_msg_sched`

## Requirements
- R1: After reset, `round_o` is 0, `word_o` is 0 and `done_o` is 1, and advance pulses are ignored until the first load.
- R2: In the cycle after `load_i` is sampled high, `round_o` is 0 and `done_o` is 0.
- R3: For rounds 0 to 15, `word_o` equals block word t, where word t is `block_i[511-32t -: 32]`, so word 0 is the top 32 bits.
- R4: For rounds 16 to 63, `word_o` equals s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16]. Here s0(x) = rotr(x,7) ^ rotr(x,18) ^ (x >> 3) and s1(x) = rotr(x,17) ^ rotr(x,19) ^ (x >> 10).
- R5: Each "+" sums every SEG_W-bit slice on its own, modulo 2^SEG_W, with no carry across slices. SEG_W may be 1, 2, 4, 8, 16 or 32, and SEG_W = 32 gives exact modulo-2^32 sums.
- R6: An advance pulse while not done and not at round 63 raises `round_o` by one and presents that round's word one cycle later. Without a pulse, `round_o` and `word_o` hold.
- R7: An advance pulse at round 63 sets `done_o`, while `round_o` stays 63 and `word_o` stays W[63].
- R8: While `done_o` is 1, advance pulses change neither `round_o`, `word_o` nor `done_o`.
- R9: A load wins over an advance in the same cycle. A load in the middle of a block restarts at round 0 with the new block's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture `block_i` and restart at round 0 |
| block_i | input | 512 | Message block, word 0 in the top bits |
| adv_i | input | 1 | Step to the next round |
| word_o | output | 32 | Schedule word of the current round |
| round_o | output | 6 | Current round index |
| done_o | output | 1 | Last round consumed, or no block loaded |

## Verification
A wrong tap, a wrong rotation amount or a stray carry across slices first shows at round 16, one cycle after the advance that reaches it. Once wrong, a word feeds later words, so a single error spreads through the rest of the block. Slice carry leaks show up only when narrow and full-width instances are compared against arithmetic models with different slice widths. A wrong counter or shift enable shows up as a round index or word that moves when it should hold, on the cycle after the pulse.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int WORD_W  = 32;
  localparam int WIN_N   = 16;
  localparam int ROUNDS  = 64;
  localparam int BLK_W   = WORD_W * WIN_N;
  localparam int RND_W   = $clog2(ROUNDS);
  // small mixing function rotations/shift
  localparam int S0_RA = 7;
  localparam int S0_RB = 18;
  localparam int S0_SH = 3;
  localparam int S1_RA = 17;
  localparam int S1_RB = 19;
  localparam int S1_SH = 10;
  // window taps relative to the oldest word
  localparam int TAP_S1 = WIN_N - 2;
  localparam int TAP_D7 = WIN_N - 7;
  localparam int TAP_S0 = 1;
  localparam int TAP_D0 = 0;
endpackage

// File: rtl/sched_seg_add.sv
module sched_seg_add #(
  parameter int W = 32,
  parameter int K = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int NSEG = W / K;

  if ((W % K) != 0) begin : g_bad_k
    $error("segment width must divide word width");
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    // carry-in zero, carry-out dropped
    assign sum_o[g*K +: K] = a_i[g*K +: K] + b_i[g*K +: K];
  end
endmodule

// File: rtl/sched_sigma.sv
module sched_sigma #(
  parameter int W  = 32,
  parameter int RA = 7,
  parameter int RB = 18,
  parameter int SH = 3
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] rot_a, rot_b, shr_c;
  assign rot_a = (x_i >> RA) | (x_i << (W - RA));
  assign rot_b = (x_i >> RB) | (x_i << (W - RB));
  assign shr_c = x_i >> SH;
  assign y_o   = rot_a ^ rot_b ^ shr_c;
endmodule

// File: rtl/sched_window.sv
module sched_window
  import sched_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [BLK_W-1:0]  block_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] win_q [WIN_N];
  logic [WORD_W-1:0] sig0, sig1, sum_hi, sum_lo, next_w;

  sched_sigma #(.W(WORD_W), .RA(S0_RA), .RB(S0_RB), .SH(S0_SH)) u_sig0 (
    .x_i(win_q[TAP_S0]), .y_o(sig0));
  sched_sigma #(.W(WORD_W), .RA(S1_RA), .RB(S1_RB), .SH(S1_SH)) u_sig1 (
    .x_i(win_q[TAP_S1]), .y_o(sig1));

  // balanced tree: two adders in parallel, then one
  sched_seg_add #(.W(WORD_W), .K(SEG_W)) u_add_hi (
    .a_i(sig1), .b_i(win_q[TAP_D7]), .sum_o(sum_hi));
  sched_seg_add #(.W(WORD_W), .K(SEG_W)) u_add_lo (
    .a_i(sig0), .b_i(win_q[TAP_D0]), .sum_o(sum_lo));
  sched_seg_add #(.W(WORD_W), .K(SEG_W)) u_add_out (
    .a_i(sum_hi), .b_i(sum_lo), .sum_o(next_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WIN_N; i++) win_q[i] <= '0;
    end else if (load_i) begin
      for (int i = 0; i < WIN_N; i++)
        win_q[i] <= block_i[BLK_W-1-i*WORD_W -: WORD_W];
    end else if (shift_i) begin
      for (int i = 0; i < WIN_N-1; i++) win_q[i] <= win_q[i+1];
      win_q[WIN_N-1] <= next_w;
    end
  end

  assign word_o = win_q[0];

  assert_load_first_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> word_o == $past(block_i[BLK_W-1 -: WORD_W]));

  assert_shift_advances_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> word_o == $past(win_q[1]));

  assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i) |=> $stable(word_o));
endmodule

// File: rtl/seg_msg_sched.sv
module seg_msg_sched
  import sched_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BLK_W-1:0]  block_i,
  input  logic              adv_i,
  output logic [WORD_W-1:0] word_o,
  output logic [RND_W-1:0]  round_o,
  output logic              done_o
);
  localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

  if (!(SEG_W == 1 || SEG_W == 2 || SEG_W == 4 || SEG_W == 8 ||
        SEG_W == 16 || SEG_W == 32)) begin : g_bad_seg
    $error("SEG_W must be 1, 2, 4, 8, 16 or 32");
  end

  logic [RND_W-1:0] rnd_q;
  logic             done_q;
  logic             shift_en;

  assign shift_en = adv_i && !done_q && !load_i && (rnd_q != LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rnd_q  <= '0;
      done_q <= 1'b1;
    end else if (load_i) begin
      rnd_q  <= '0;
      done_q <= 1'b0;
    end else if (adv_i && !done_q) begin
      if (rnd_q == LAST) done_q <= 1'b1;
      else               rnd_q  <= rnd_q + 1'b1;
    end
  end

  sched_window #(.SEG_W(SEG_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .shift_i(shift_en),
    .block_i(block_i),
    .word_o (word_o)
  );

  assign round_o = rnd_q;
  assign done_o  = done_q;

  assert_load_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (round_o == '0) && !done_o);

  assert_round_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !done_o && round_o != LAST) |=>
      round_o == RND_W'($past(round_o) + 1'b1));

  assert_done_at_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !done_o && round_o == LAST) |=>
      done_o && round_o == LAST && $stable(word_o));

  assert_ignore_when_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o && $stable(round_o) && $stable(word_o));
endmodule

// File: tb/sim_seg_msg_sched.sv
module sim_seg_msg_sched;
  localparam int CLK_NS = 8;
  localparam int ND = 3;
  localparam int KD0 = 4;
  localparam int KD1 = 32;
  localparam int KD2 = 1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic         adv_i = 1'b0;
  logic [511:0] block_i = '0;

  logic [31:0] word_w [ND];
  logic [5:0]  rnd_w  [ND];
  logic        done_w [ND];
  logic [31:0] exp_q  [ND][64];
  int          k_of   [ND];

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  seg_msg_sched #(.SEG_W(KD0)) u0 (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .block_i(block_i), .adv_i(adv_i), .word_o(word_w[0]), .round_o(rnd_w[0]), .done_o(done_w[0]));
  seg_msg_sched #(.SEG_W(KD1)) u1 (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .block_i(block_i), .adv_i(adv_i), .word_o(word_w[1]), .round_o(rnd_w[1]), .done_o(done_w[1]));
  seg_msg_sched #(.SEG_W(KD2)) u2 (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .block_i(block_i), .adv_i(adv_i), .word_o(word_w[2]), .round_o(rnd_w[2]), .done_o(done_w[2]));

  function automatic logic [31:0] rotr(logic [31:0] x, int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  function automatic logic [31:0] ref_s0(logic [31:0] x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] ref_s1(logic [31:0] x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  // R5 model: slice-wise sum, each slice mod 2^k
  function automatic logic [31:0] ref_add(logic [31:0] a, logic [31:0] b, int k);
    logic [63:0] r, m, sa, sb;
    r = '0;
    m = (64'd1 << k) - 64'd1;
    for (int s = 0; s < 32; s += k) begin
      sa = ({32'd0, a} >> s) & m;
      sb = ({32'd0, b} >> s) & m;
      r  = r | (((sa + sb) & m) << s);
    end
    return r[31:0];
  endfunction

  task automatic build_all(input logic [511:0] blk);
    for (int d = 0; d < ND; d++) begin
      for (int t = 0; t < 16; t++) exp_q[d][t] = blk[511-32*t -: 32];
      for (int t = 16; t < 64; t++)
        exp_q[d][t] = ref_add(ref_add(ref_s1(exp_q[d][t-2]), exp_q[d][t-7], k_of[d]),
                              ref_add(ref_s0(exp_q[d][t-15]), exp_q[d][t-16], k_of[d]),
                              k_of[d]);
    end
  endtask

  task automatic chk(input string tag, input int d, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s dut%0d k=%0d act=%h exp=%h", tag, d, k_of[d], act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input int r, input logic dn, input logic use_exp);
    for (int d = 0; d < ND; d++) begin
      chk({tag, " round"}, d, 32'(rnd_w[d]), 32'(r));
      chk({tag, " done"}, d, 32'(done_w[d]), 32'(dn));
      if (use_exp) chk({tag, " word"}, d, word_w[d], exp_q[d][r]);
    end
  endtask

  task automatic pulse_adv();
    adv_i = 1'b1;
    @(negedge clk_i);
    adv_i = 1'b0;
  endtask

  task automatic do_load(input logic [511:0] blk, input logic with_adv);
    build_all(blk);
    block_i = blk;
    load_i = 1'b1;
    adv_i = with_adv;
    @(negedge clk_i);
    load_i = 1'b0;
    adv_i = 1'b0;
  endtask

  task automatic run_block(input logic [511:0] blk);
    do_load(blk, 1'b0);
    chk_state("R2 after load", 0, 1'b0, 1'b1);
    for (int r = 0; r < 64; r++) begin
      if (r < 16) chk_state("R3 block word", r, 1'b0, 1'b1);
      else        chk_state("R4 R5 derived word", r, 1'b0, 1'b1);
      if (r == 20) begin
        @(negedge clk_i);
        chk_state("R6 hold without advance", r, 1'b0, 1'b1);
      end
      if (r < 63) pulse_adv();
    end
    pulse_adv();
    chk_state("R7 done after last", 63, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) begin
      pulse_adv();
      chk_state("R8 advance ignored when done", 63, 1'b1, 1'b1);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [511:0] blk;
    logic [31:0]  x;
    k_of[0] = KD0;
    k_of[1] = KD1;
    k_of[2] = KD2;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int d = 0; d < ND; d++) begin
      chk("R1 reset round", d, 32'(rnd_w[d]), 32'd0);
      chk("R1 reset word", d, word_w[d], 32'd0);
      chk("R1 reset done", d, 32'(done_w[d]), 32'd1);
    end
    pulse_adv();
    for (int d = 0; d < ND; d++) begin
      chk("R1 advance before load round", d, 32'(rnd_w[d]), 32'd0);
      chk("R1 advance before load done", d, 32'(done_w[d]), 32'd1);
    end

    // padded three-byte message, exact schedule at k=32
    blk = '0;
    blk[511 -: 32] = 32'h61626380;
    blk[31:0] = 32'h00000018;
    run_block(blk);

    run_block({512{1'b1}});

    for (int i = 0; i < 16; i++) blk[511-32*i -: 32] = 32'h00010203 + 32'h04040404 * i;
    run_block(blk);

    x = 32'h2545f491;
    for (int i = 0; i < 16; i++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      blk[511-32*i -: 32] = x;
    end
    run_block(blk);

    // R9: load and advance in the same cycle
    blk = {16{32'h89abcdef}};
    do_load(blk, 1'b1);
    chk_state("R9 load beats advance", 0, 1'b0, 1'b1);
    for (int r = 1; r <= 18; r++) begin
      pulse_adv();
      chk_state("R9 stepping", r, 1'b0, 1'b1);
    end
    // R9: mid-block reload
    for (int i = 0; i < 16; i++) blk[511-32*i -: 32] = 32'hf0e1d2c3 ^ (32'h11111111 * i);
    do_load(blk, 1'b0);
    chk_state("R9 reload restarts", 0, 1'b0, 1'b1);
    for (int r = 1; r < 20; r++) begin
      pulse_adv();
      chk_state("R9 after reload", r, 1'b0, 1'b1);
    end

    finish_up();
  end
endmodule